// File: doc/BRIEF.md
# Reset Sequencer with Configuration Strap Capture

This block watches the processor reset pin and turns it into a clean internal core reset. It also latches the configuration straps the board presents during reset. While the reset pin is sampled high, the block counts consecutive high samples. When the pin falls, it compares that count with the minimum assertion width. A warm reset has a fixed minimum of 15 clocks. A power-on reset uses a longer, parameterised clock count in place of a real-time interval, and an input picks which minimum applies.

On a valid negation, the block latches the 3-bit bus-ratio strap and the active-low flush strap. Both are the values present at the last clock edge where reset was still seen high. For the next two edges it checks that neither strap has moved. On the edge after that check window it releases the core reset. If the flush strap was captured asserted, it emits a single-cycle flush request at the same moment.

A reset that is too short raises a short-reset flag and leaves the previous straps in place. A strap that moves inside the check window raises a hold flag, and the value latched at negation is kept.

Top module: `rsq_reset_sequencer`

## Requirements
- R1: After the block's own synchronous reset `rst`, `core_rst` is 1 and `bus_ratio`, `flush_strap`, `flush_pulse`, `err_short` and `err_hold` are all 0.
- R2: On every edge where `reset_pin` is sampled 1, `core_rst` is 1 and `flush_pulse` is 0 from the following cycle.
- R3: With `power_on` = 0, a reset of 15 or more consecutive high samples is valid. A reset of fewer high samples sets `err_short` in the cycle after the first low sample. In that case `bus_ratio` and `flush_strap` stay unchanged and `core_rst` stays 1.
- R4: With `power_on` = 1 (sampled at the first low edge), the minimum is the parameter `POR_MIN` instead of 15.
- R5: On a valid negation, `bus_ratio` takes the `strap_ratio` value and `flush_strap` takes the inverse of `strap_flush_n`, both from the last edge where `reset_pin` was 1. Both outputs are visible in the cycle after the first low edge.
- R6: At the first and second low edges after negation, if `strap_ratio` or `strap_flush_n` differs from the captured value, `err_hold` becomes 1 and the latched straps are not altered.
- R7: After a valid negation, `core_rst` falls at the third consecutive low edge and stays 0 while `reset_pin` stays 0.
- R8: `flush_pulse` is 1 for exactly one cycle, in the cycle `core_rst` first reads 0, and only if `flush_strap` is 1.
- R9: A new assertion of `reset_pin` clears `err_short` and `err_hold`. A reassertion before release aborts the sequence, and `core_rst` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the block |
| reset_pin | input | 1 | Monitored processor reset, active high, synchronous |
| power_on | input | 1 | 1 selects the power-on minimum width |
| strap_ratio | input | 3 | Bus-ratio strap pins |
| strap_flush_n | input | 1 | Flush strap, active low |
| bus_ratio | output | 3 | Latched bus-ratio strap |
| flush_strap | output | 1 | Latched flush strap, 1 = flush requested |
| core_rst | output | 1 | Internal core reset, active high |
| flush_pulse | output | 1 | One-cycle flush-on-reset request at release |
| err_short | output | 1 | Last reset was shorter than the minimum |
| err_hold | output | 1 | A strap moved in the post-negation window |

## Verification
A miscounted width counter shows up at the first low edge of a reset near the threshold: 14 versus 15 warm samples, or POR_MIN-1 versus POR_MIN. It appears as a wrong `err_short`, or as straps that update when they should not, one cycle later. A sequencer state that is off by one moves the falling edge of `core_rst` and of `flush_pulse` by a cycle, which the per-cycle comparison catches immediately. A shadow register captured on the wrong edge produces a wrong `bus_ratio` in the cycle after negation. It also produces a spurious or missing `err_hold` when the straps change right at negation.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  typedef enum logic [1:0] {
    RSQ_IDLE   = 2'd0,
    RSQ_ASSERT = 2'd1,
    RSQ_HOLD   = 2'd2,
    RSQ_REL    = 2'd3
  } rsq_state_e;
endpackage

// File: rtl/rsq_width_cnt.sv
module rsq_width_cnt #(
  parameter int WARM_MIN = 15,
  parameter int POR_MIN  = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_hi,
  input  logic por_sel,
  output logic width_ok
);
  localparam int MAXC  = (POR_MIN > WARM_MIN) ? POR_MIN : WARM_MIN;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] MAX_V  = CNT_W'(MAXC);
  localparam logic [CNT_W-1:0] WARM_V = CNT_W'(WARM_MIN);
  localparam logic [CNT_W-1:0] POR_V  = CNT_W'(POR_MIN);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !pin_hi) cnt_q <= '0;
    else if (cnt_q != MAX_V) cnt_q <= cnt_q + 1'b1;
  end

  assign width_ok = cnt_q >= (por_sel ? POR_V : WARM_V);

  // R3: count restarts once the pin is seen low
  p_cnt_cleared_r3: assert property (@(posedge clk) disable iff (rst)
    !pin_hi |=> cnt_q == '0);
  // R3: counter never passes its ceiling
  p_cnt_bounded_r3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= MAX_V);
endmodule

// File: rtl/rsq_strap_cap.sv
module rsq_strap_cap #(
  parameter int RATIO_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pin_hi,
  input  logic               capture_en,
  input  logic               check_en,
  input  logic [RATIO_W-1:0] ratio_in,
  input  logic               flush_n_in,
  output logic [RATIO_W-1:0] ratio_q,
  output logic               flush_q,
  output logic               hold_bad
);
  logic [RATIO_W-1:0] sh_ratio_q;
  logic               sh_flush_n_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_ratio_q   <= '0;
      sh_flush_n_q <= 1'b1;
    end else if (pin_hi) begin
      sh_ratio_q   <= ratio_in;
      sh_flush_n_q <= flush_n_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ratio_q <= '0;
      flush_q <= 1'b0;
    end else if (capture_en) begin
      ratio_q <= sh_ratio_q;
      flush_q <= !sh_flush_n_q;
    end
  end

  assign hold_bad = check_en &&
                    ((ratio_in != sh_ratio_q) || (flush_n_in != sh_flush_n_q));

  // R5: latched straps move only at a capture
  p_latch_stable_r5: assert property (@(posedge clk) disable iff (rst)
    !capture_en |=> $stable(ratio_q) && $stable(flush_q));
endmodule

// File: rtl/rsq_reset_sequencer.sv
module rsq_reset_sequencer #(
  parameter int WARM_MIN = 15,
  parameter int POR_MIN  = 64,
  parameter int RATIO_W  = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reset_pin,
  input  logic               power_on,
  input  logic [RATIO_W-1:0] strap_ratio,
  input  logic               strap_flush_n,
  output logic [RATIO_W-1:0] bus_ratio,
  output logic               flush_strap,
  output logic               core_rst,
  output logic               flush_pulse,
  output logic               err_short,
  output logic               err_hold
);
  import rsq_pkg::*;

  rsq_state_e state_q;
  logic width_ok, neg_seen, capture_en, check_en, hold_bad;
  logic core_rst_q, pulse_q, err_short_q, err_hold_q;

  rsq_width_cnt #(.WARM_MIN(WARM_MIN), .POR_MIN(POR_MIN)) u_cnt (
    .clk(clk), .rst(rst), .pin_hi(reset_pin), .por_sel(power_on),
    .width_ok(width_ok)
  );

  assign neg_seen   = (state_q == RSQ_ASSERT) && !reset_pin;
  assign capture_en = neg_seen && width_ok;
  assign check_en   = capture_en || ((state_q == RSQ_HOLD) && !reset_pin);

  rsq_strap_cap #(.RATIO_W(RATIO_W)) u_cap (
    .clk(clk), .rst(rst), .pin_hi(reset_pin),
    .capture_en(capture_en), .check_en(check_en),
    .ratio_in(strap_ratio), .flush_n_in(strap_flush_n),
    .ratio_q(bus_ratio), .flush_q(flush_strap), .hold_bad(hold_bad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= RSQ_IDLE;
      core_rst_q  <= 1'b1;
      pulse_q     <= 1'b0;
      err_short_q <= 1'b0;
      err_hold_q  <= 1'b0;
    end else if (reset_pin) begin
      if (state_q != RSQ_ASSERT) begin
        err_short_q <= 1'b0;
        err_hold_q  <= 1'b0;
      end
      state_q    <= RSQ_ASSERT;
      core_rst_q <= 1'b1;
      pulse_q    <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (hold_bad) err_hold_q <= 1'b1;
      unique case (state_q)
        RSQ_ASSERT: begin
          if (width_ok) state_q <= RSQ_HOLD;
          else begin
            state_q     <= RSQ_IDLE;
            err_short_q <= 1'b1;
          end
        end
        RSQ_HOLD: state_q <= RSQ_REL;
        RSQ_REL: begin
          state_q    <= RSQ_IDLE;
          core_rst_q <= 1'b0;
          pulse_q    <= flush_strap;
        end
        default: state_q <= RSQ_IDLE;
      endcase
    end
  end

  assign core_rst    = core_rst_q;
  assign flush_pulse = pulse_q;
  assign err_short   = err_short_q;
  assign err_hold    = err_hold_q;

  p_core_held_r2: assert property (@(posedge clk) disable iff (rst)
    reset_pin |=> core_rst_q && !pulse_q);
  p_short_keeps_straps_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(err_short_q) |-> $stable(bus_ratio) && core_rst_q);
  p_release_after_window_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(core_rst_q) |-> !$past(reset_pin) && !$past(reset_pin, 2) && !$past(reset_pin, 3));
  p_pulse_single_r8: assert property (@(posedge clk) disable iff (rst)
    pulse_q |=> !pulse_q);
  p_pulse_at_release_r8: assert property (@(posedge clk) disable iff (rst)
    pulse_q |-> $fell(core_rst_q) && flush_strap);
  p_err_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (reset_pin && !$past(reset_pin)) |=> !err_short_q && !err_hold_q);
endmodule

// File: tb/tb_rsq_reset_sequencer.sv
module tb_rsq_reset_sequencer;
  localparam int CLK_NS = 10;
  localparam int WARM   = 15;
  localparam int PORMIN = 32;

  logic clk = 1'b0;
  logic rst, reset_pin, power_on, strap_flush_n;
  logic [2:0] strap_ratio;
  logic [2:0] bus_ratio;
  logic flush_strap, core_rst, flush_pulse, err_short, err_hold;

  int total = 0;
  int bad   = 0;
  bit cmp_on = 1'b0;
  bit done   = 1'b0;

  rsq_reset_sequencer #(.WARM_MIN(WARM), .POR_MIN(PORMIN), .RATIO_W(3)) dut (
    .clk(clk), .rst(rst), .reset_pin(reset_pin), .power_on(power_on),
    .strap_ratio(strap_ratio), .strap_flush_n(strap_flush_n),
    .bus_ratio(bus_ratio), .flush_strap(flush_strap), .core_rst(core_rst),
    .flush_pulse(flush_pulse), .err_short(err_short), .err_hold(err_hold)
  );

  always #(CLK_NS/2) clk = ~clk;

  // behavioural reference model
  int hc, phase, pulses;
  logic [2:0] sbf, e_ratio;
  logic sfl, e_flush, e_core, e_pulse, e_es, e_eh;

  always @(posedge clk) begin
    if (rst) begin
      hc = 0; phase = 0; sbf = 0; sfl = 1;
      e_ratio = 0; e_flush = 0; e_core = 1; e_pulse = 0; e_es = 0; e_eh = 0;
    end else if (reset_pin) begin
      if (phase != 1) begin e_es = 0; e_eh = 0; end
      phase = 1; e_core = 1; e_pulse = 0;
      sbf = strap_ratio; sfl = strap_flush_n;
      if (hc < 1000) hc = hc + 1;
    end else begin
      e_pulse = 0;
      if (phase == 1) begin
        if (hc >= (power_on ? PORMIN : WARM)) begin
          e_ratio = sbf; e_flush = !sfl;
          if (strap_ratio != sbf || strap_flush_n != sfl) e_eh = 1;
          phase = 2;
        end else begin
          e_es = 1; phase = 0;
        end
      end else if (phase == 2) begin
        if (strap_ratio != sbf || strap_flush_n != sfl) e_eh = 1;
        phase = 3;
      end else if (phase == 3) begin
        e_core = 0; e_pulse = e_flush; phase = 0;
      end
      hc = 0;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R5", "bus_ratio", int'(bus_ratio), int'(e_ratio));
      chk("R5", "flush_strap", int'(flush_strap), int'(e_flush));
      chk("R7", "core_rst", int'(core_rst), int'(e_core));
      chk("R8", "flush_pulse", int'(flush_pulse), int'(e_pulse));
      chk("R3", "err_short", int'(err_short), int'(e_es));
      chk("R6", "err_hold", int'(err_hold), int'(e_eh));
      if (flush_pulse) pulses++;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_reset(input int n, input logic [2:0] bf, input logic fl);
    @(negedge clk);
    reset_pin = 1; strap_ratio = bf; strap_flush_n = fl;
    idle(n);
    reset_pin = 0;
  endtask

  initial begin
    #(CLK_NS * 100000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1; reset_pin = 0; power_on = 0; strap_ratio = 0; strap_flush_n = 1;
    pulses = 0;
    idle(3);
    rst = 0;
    cmp_on = 1;
    // R1 reset state
    chk("R1", "core_rst", int'(core_rst), 1);
    chk("R1", "outputs", int'({bus_ratio, flush_strap, flush_pulse, err_short, err_hold}), 0);

    // R5 R7 R8: valid warm reset with flush strap low
    pulse_reset(20, 3'd5, 1'b0);
    idle(6);
    chk("R5", "ratio after warm", int'(bus_ratio), 5);
    chk("R5", "flush latched", int'(flush_strap), 1);
    chk("R7", "released", int'(core_rst), 0);
    chk("R8", "one pulse", pulses, 1);

    // R3: 14 clocks is short
    pulse_reset(14, 3'd2, 1'b1);
    idle(4);
    chk("R3", "short flag", int'(err_short), 1);
    chk("R3", "ratio kept", int'(bus_ratio), 5);
    chk("R3", "core held", int'(core_rst), 1);

    // R3: exactly 15 is enough; R9 clears the error
    pulse_reset(15, 3'd3, 1'b1);
    idle(5);
    chk("R9", "short cleared", int'(err_short), 0);
    chk("R3", "ratio at 15", int'(bus_ratio), 3);
    chk("R8", "no pulse without flush", pulses, 1);

    // R4: power-on minimum
    power_on = 1;
    pulse_reset(20, 3'd6, 1'b1);
    idle(4);
    chk("R4", "20 short at power-on", int'(err_short), 1);
    pulse_reset(PORMIN - 1, 3'd1, 1'b1);
    idle(4);
    chk("R4", "min-1 short", int'(err_short), 1);
    pulse_reset(PORMIN, 3'd4, 1'b0);
    idle(5);
    chk("R4", "min ok", int'(bus_ratio), 4);
    chk("R4", "released", int'(core_rst), 0);
    power_on = 0;

    // R6: strap moves at first low edge
    pulse_reset(18, 3'd6, 1'b1);
    strap_ratio = 3'd1;
    idle(5);
    chk("R6", "hold flag", int'(err_hold), 1);
    chk("R6", "ratio kept", int'(bus_ratio), 6);

    // R6: flush moves at second low edge
    pulse_reset(18, 3'd7, 1'b1);
    @(negedge clk);
    strap_flush_n = 1'b0;
    idle(4);
    chk("R6", "hold flag late", int'(err_hold), 1);
    chk("R6", "flush kept", int'(flush_strap), 0);

    // R9: reassert during hold aborts
    pulse_reset(16, 3'd2, 1'b1);
    @(negedge clk);
    reset_pin = 1;
    idle(2);
    chk("R9", "errors clear", int'({err_short, err_hold}), 0);
    chk("R2", "core held on reassert", int'(core_rst), 1);
    idle(14);
    reset_pin = 0;
    idle(6);
    chk("R9", "released after retry", int'(core_rst), 0);
    chk("R2", "ratio after retry", int'(bus_ratio), 2);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule